// File: doc/BRIEF.md
# Multi-Channel Event Timer

This block is a memory-mapped event timer. A single 64-bit main counter advances by one on every clock while the block is enabled. Several comparator channels watch that counter. Each channel raises an interrupt when the counter reaches the channel's comparator value. The interrupt is either one-shot or periodic. A periodic channel adds its reload period to the comparator after every match.

Software reaches the block through a plain 32-bit register port. Writes take effect on the clock edge, and reads are combinational. Each channel has its own interrupt output. When legacy routing is switched on, the first two channels instead drive two dedicated lines, one for the legacy system tick and one for the legacy real-time clock. Each channel also stores a route field, which is held only for the interrupt controller to read.

Top module: `evt_tmr`

## Requirements
- R1: Offset 0x00 reads as {vendor[31:16], legacy-capable[15], 2'b00, channels-minus-one[12:8], revision 8'h01}, and offset 0x04 reads the constant tick period in femtoseconds. Elaboration rejects a period outside 100,000 to 100,000,000.
- R2: After reset, the general configuration at 0x08 (bit 0 enable, bit 1 legacy routing), the status register at 0x0C and the main counter all read zero, and no interrupt output is high.
- R3: While enable is set, the main counter rises by exactly one per clock. While enable is clear, it holds its value.
- R4: The counter halves at 0x10 (low) and 0x14 (high) load only while the counter is halted. A write to either half while it runs is ignored.
- R5: A one-shot channel matches only when the counter equals its comparator. A comparator value behind the counter raises nothing until the counter comes round again.
- R6: A periodic channel adds its reload period to the comparator on every match, so it matches at S, S+P, S+2P and so on.
- R7: Channel registers start at 0x20 + 0x10*n: +0 configuration (bit 0 interrupt enable, bit 1 periodic, bit 2 set-value, bit 3 32-bit mode, bits 8:4 route), +4 comparator low, +8 comparator high. With periodic and set-value both set, the first comparator-low write (with the preceding high write) sets the next match, and the second sets the period. Set-value then reads back as zero.
- R8: In 32-bit mode a channel compares and reloads using only the low 32 bits of the counter, so it fires again after the low half wraps.
- R9: Status bit n at 0x0C sets on a match of channel n while its interrupt enable is set, and clears only on a write of one. A channel's interrupt is high exactly while its status bit is set and it is enabled.
- R10: With legacy routing set, channel 0 drives legacy_tmr_irq and channel 1 drives legacy_rtc_irq, and their own chan_irq bits stay low.
- R11: The route field is stored as written and reads back unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 8 | Byte address, word aligned |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| chan_irq | output | NCH | Per-channel interrupt |
| legacy_tmr_irq | output | 1 | Legacy system-tick line (channel 0 when routed) |
| legacy_rtc_irq | output | 1 | Legacy real-time-clock line (channel 1 when routed) |

## Verification
The case that is hardest to reach from the ports is the counter wrapping underneath a comparator. A 32-bit channel needs 2^32 cycles to come round from reset, which is far too long to simulate. The stimulus therefore halts the counter, loads it a few counts short of the low-half wrap and restarts it. The bench then checks that the 32-bit channel fires at the wrapped low value, and that a 64-bit comparator loaded behind the counter stays silent. The two-write set-value sequence is driven directly, and the time of every later periodic match is predicted from the start value and the period. Random one-shot arms on random channels cover the ordinary match path.

// File: rtl/evt_tmr_pkg.sv
package evt_tmr_pkg;
   localparam logic [7:0] A_ID   = 8'h00;
   localparam logic [7:0] A_PER  = 8'h04;
   localparam logic [7:0] A_GCFG = 8'h08;
   localparam logic [7:0] A_STS  = 8'h0C;
   localparam logic [7:0] A_CLO  = 8'h10;
   localparam logic [7:0] A_CHI  = 8'h14;
   localparam int CNT_W = 64;
   localparam int CFG_W = 9;

   typedef struct packed {
      logic [4:0] route;
      logic       m32;
      logic       sv;
      logic       per;
      logic       ien;
   } chan_cfg_t;
endpackage

// File: rtl/evt_tmr_counter.sv
module evt_tmr_counter
   import evt_tmr_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             lo_we,
   input  logic             hi_we,
   input  logic [31:0]      wdata,
   output logic [CNT_W-1:0] cnt
);
   always_ff @(posedge clk) begin
      if (!rst_n)     cnt <= '0;
      else if (run)   cnt <= cnt + 64'd1;
      else if (lo_we) cnt[31:0] <= wdata;
      else if (hi_we) cnt[63:32] <= wdata;
   end

   assert_count_R3: assert property (@(posedge clk) disable iff (!rst_n)
      run |=> cnt == $past(cnt) + 64'd1);
   assert_halt_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!run && !lo_we && !hi_we) |=> $stable(cnt));
endmodule

// File: rtl/evt_tmr_channel.sv
module evt_tmr_channel
   import evt_tmr_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [CNT_W-1:0] cnt,
   input  logic             cfg_we,
   input  logic [CFG_W-1:0] cfg_wdata,
   input  logic             lo_we,
   input  logic             hi_we,
   input  logic [31:0]      wdata,
   output chan_cfg_t        cfg_q,
   output logic [CNT_W-1:0] cmp_q,
   output logic             hit
);
   logic [CNT_W-1:0] per_q;
   logic             phase_q;
   logic             sv_on;
   logic             to_per;

   assign sv_on  = cfg_q.per && cfg_q.sv;
   assign to_per = sv_on && phase_q;
   assign hit    = run && (cfg_q.m32 ? (cnt[31:0] == cmp_q[31:0]) : (cnt == cmp_q));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cfg_q   <= '0;
         cmp_q   <= '1;
         per_q   <= '0;
         phase_q <= 1'b0;
      end else if (cfg_we) begin
         cfg_q   <= chan_cfg_t'(cfg_wdata);
         phase_q <= 1'b0;
      end else if (lo_we || hi_we) begin
         if (to_per) begin
            if (lo_we) per_q[31:0]  <= wdata;
            else       per_q[63:32] <= wdata;
         end else begin
            if (lo_we) cmp_q[31:0]  <= wdata;
            else       cmp_q[63:32] <= wdata;
         end
         if (lo_we && sv_on) begin
            phase_q <= !phase_q;
            if (phase_q) cfg_q.sv <= 1'b0;
         end
      end else if (hit && cfg_q.per) begin
         if (cfg_q.m32) cmp_q[31:0] <= cmp_q[31:0] + per_q[31:0];
         else           cmp_q       <= cmp_q + per_q;
      end
   end

   assert_reload_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && cfg_q.per && !cfg_q.m32 && !cfg_we && !lo_we && !hi_we)
      |=> cmp_q == $past(cmp_q) + $past(per_q));
   assert_svclear_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(cfg_q.sv) |-> ($past(lo_we) || $past(cfg_we)));
endmodule

// File: rtl/evt_tmr.sv
module evt_tmr
   import evt_tmr_pkg::*;
#(
   parameter int          NCH       = 3,
   parameter logic [15:0] VENDOR    = 16'hA5C3,
   parameter int          PERIOD_FS = 10_000_000,
   parameter bit          LEG_CAP   = 1'b1
)(
   input  logic           clk,
   input  logic           rst_n,
   input  logic           bus_wr,
   input  logic [7:0]     bus_addr,
   input  logic [31:0]    bus_wdata,
   output logic [31:0]    bus_rdata,
   output logic [NCH-1:0] chan_irq,
   output logic           legacy_tmr_irq,
   output logic           legacy_rtc_irq
);
   if (NCH < 2 || NCH > 12) begin : g_bad_nch
      $error("NCH must lie in 2..12");
   end
   if (PERIOD_FS < 100_000 || PERIOD_FS > 100_000_000) begin : g_bad_period
      $error("PERIOD_FS out of range");
   end

   logic             aligned, in_ch, en_q, leg_q, leg_on;
   logic [3:0]       cidx;
   logic [1:0]       creg;
   logic [CNT_W-1:0] cnt;
   logic [NCH-1:0]   hit, ien_vec, sts_q, raw_irq, leg_mask;
   chan_cfg_t        cfg_arr [NCH];
   logic [CNT_W-1:0] cmp_arr [NCH];

   assign aligned = bus_addr[1:0] == 2'b00;
   assign in_ch   = aligned && bus_addr >= 8'h20;
   assign cidx    = bus_addr[7:4] - 4'd2;
   assign creg    = bus_addr[3:2];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         en_q  <= 1'b0;
         leg_q <= 1'b0;
      end else if (bus_wr && bus_addr == A_GCFG) begin
         en_q  <= bus_wdata[0];
         leg_q <= bus_wdata[1];
      end
   end

   if (LEG_CAP) begin : g_leg
      assign leg_on = leg_q;
   end else begin : g_noleg
      assign leg_on = 1'b0;
   end

   evt_tmr_counter u_cnt (
      .clk(clk), .rst_n(rst_n), .run(en_q),
      .lo_we(bus_wr && bus_addr == A_CLO),
      .hi_we(bus_wr && bus_addr == A_CHI),
      .wdata(bus_wdata), .cnt(cnt)
   );

   for (genvar i = 0; i < NCH; i++) begin : g_ch
      logic sel;
      assign sel = bus_wr && in_ch && cidx == 4'(i);
      evt_tmr_channel u_ch (
         .clk(clk), .rst_n(rst_n), .run(en_q), .cnt(cnt),
         .cfg_we(sel && creg == 2'd0), .cfg_wdata(bus_wdata[CFG_W-1:0]),
         .lo_we(sel && creg == 2'd1), .hi_we(sel && creg == 2'd2),
         .wdata(bus_wdata), .cfg_q(cfg_arr[i]), .cmp_q(cmp_arr[i]), .hit(hit[i])
      );
      assign ien_vec[i]  = cfg_arr[i].ien;
      assign leg_mask[i] = leg_on && (i < 2);

      assert_stsrc_R9: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(sts_q[i]) |-> ($past(hit[i]) && $past(ien_vec[i])));
      assert_irqsrc_R9: assert property (@(posedge clk) disable iff (!rst_n)
         chan_irq[i] |-> sts_q[i]);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) sts_q <= '0;
      else begin
         sts_q <= (sts_q & ~((bus_wr && bus_addr == A_STS) ? bus_wdata[NCH-1:0] : '0))
                  | (hit & ien_vec);
      end
   end

   assign raw_irq        = sts_q & ien_vec;
   assign chan_irq       = raw_irq & ~leg_mask;
   assign legacy_tmr_irq = leg_on && raw_irq[0];
   assign legacy_rtc_irq = leg_on && raw_irq[1];

   assert_legacy_R10: assert property (@(posedge clk) disable iff (!rst_n)
      leg_on |-> !chan_irq[0] && !chan_irq[1]);

   always_comb begin
      bus_rdata = '0;
      case (bus_addr)
         A_ID:   bus_rdata = {VENDOR, LEG_CAP, 2'b00, 5'(NCH - 1), 8'h01};
         A_PER:  bus_rdata = 32'(PERIOD_FS);
         A_GCFG: bus_rdata = {30'd0, leg_on, en_q};
         A_STS:  bus_rdata = 32'(sts_q);
         A_CLO:  bus_rdata = cnt[31:0];
         A_CHI:  bus_rdata = cnt[63:32];
         default: begin
            for (int i = 0; i < NCH; i++) begin
               if (in_ch && cidx == 4'(i)) begin
                  case (creg)
                     2'd0:    bus_rdata = {23'd0, cfg_arr[i]};
                     2'd1:    bus_rdata = cmp_arr[i][31:0];
                     2'd2:    bus_rdata = cmp_arr[i][63:32];
                     default: bus_rdata = '0;
                  endcase
               end
            end
         end
      endcase
   end
endmodule

// File: tb/test_evt_tmr.sv
module test_evt_tmr;
   logic        clk = 0;
   logic        rst_n = 0;
   logic        bus_wr = 0;
   logic [7:0]  bus_addr = 0;
   logic [31:0] bus_wdata = 0;
   logic [31:0] bus_rdata;
   logic [2:0]  chan_irq;
   logic        legacy_tmr_irq, legacy_rtc_irq;
   int checks = 0, bad = 0;
   bit done = 0;

   always #2 clk = ~clk;

   evt_tmr i_evt_tmr (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .chan_irq(chan_irq),
      .legacy_tmr_irq(legacy_tmr_irq), .legacy_rtc_irq(legacy_rtc_irq)
   );

   function automatic logic [7:0] chb(input int ch);
      return 8'h20 + 8'(ch * 16);
   endfunction

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = d;
      @(negedge clk); bus_wr = 0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      @(negedge clk); bus_addr = a; #1; d = bus_rdata;
   endtask

   task automatic wait_irq(input int ch);
      int n = 0;
      do begin @(negedge clk); n++; end while (!chan_irq[ch] && n < 3000);
   endtask

   task automatic arm(input int ch, input logic [31:0] cfgv,
                      input logic [63:0] cmp, input logic [63:0] c0);
      wr(8'h08, 0);
      wr(8'h10, c0[31:0]); wr(8'h14, c0[63:32]);
      wr(chb(ch), cfgv);
      wr(chb(ch) + 8'h08, cmp[63:32]); wr(chb(ch) + 8'h04, cmp[31:0]);
      wr(8'h0C, 32'h7);
   endtask

   initial begin
      #(4 * 150000);
      if (!done) begin
         bad++; checks++;
         $display("FAIL watchdog expired");
         $display("  test done: total=%0d bad=%0d", checks, bad);
         $finish;
      end
   end

   initial begin
      logic [31:0] v, v2;
      void'($urandom(32'd1234));
      repeat (3) @(negedge clk);
      rst_n = 1;
      // R2 reset state
      rd(8'h08, v); chk("R2 gcfg", v, 0);
      rd(8'h0C, v); chk("R2 status", v, 0);
      rd(8'h10, v); chk("R2 count", v, 0);
      chk("R2 irq", {chan_irq, legacy_tmr_irq, legacy_rtc_irq}, 0);
      // R1 identity
      rd(8'h00, v); chk("R1 id", v, 32'hA5C3_8201);
      rd(8'h04, v); chk("R1 period", v, 32'd10_000_000);
      // R4 halted load
      wr(8'h10, 32'h0000_1000); wr(8'h14, 32'h0000_0002);
      rd(8'h10, v); chk("R4 load lo", v, 32'h1000);
      rd(8'h14, v); chk("R4 load hi", v, 32'h2);
      rd(8'h10, v); chk("R3 halted hold", v, 32'h1000);
      // R3 running
      wr(8'h08, 1);
      rd(8'h10, v); repeat (9) @(negedge clk); rd(8'h10, v2);
      chk("R3 increment", v2 - v, 10);
      rd(8'h10, v); wr(8'h10, 32'hDEAD_0000); rd(8'h10, v2);
      chk("R4 write ignored while running", v2, v + 3);
      // R5 one-shot exact
      arm(0, 1, 64'd40, 0); wr(8'h08, 1); wait_irq(0);
      rd(8'h10, v); chk("R5 oneshot time", v, 42);
      rd(8'h0C, v); chk("R9 status set", v[0], 1);
      wr(8'h0C, 0); rd(8'h0C, v); chk("R9 zero write keeps", v[0], 1);
      wr(8'h0C, 1); rd(8'h0C, v); chk("R9 w1c clears", v[0], 0);
      chk("R9 irq low after clear", chan_irq[0], 0);
      // R5 past value waits
      arm(0, 1, 64'd50, 64'd100); wr(8'h08, 1);
      repeat (200) @(negedge clk);
      chk("R5 past no fire", chan_irq[0], 0);
      // R9 disabled channel does not latch
      arm(2, 0, 64'd10, 0); wr(8'h08, 1);
      repeat (50) @(negedge clk);
      rd(8'h0C, v); chk("R9 ien off no status", v[2], 0);
      chk("R9 ien off no irq", chan_irq[2], 0);
      // R8 32-bit wrap
      arm(1, 32'h9, 64'd5, 64'h0000_0000_FFFF_FFF0); wr(8'h08, 1); wait_irq(1);
      rd(8'h10, v); chk("R8 wrap low", v, 7);
      wr(8'h08, 0); rd(8'h14, v); chk("R8 wrap high", v, 1);
      // R7 / R6 periodic with set-value
      wr(8'h10, 0); wr(8'h14, 0); wr(8'h0C, 7);
      wr(chb(0), 32'h7);
      wr(chb(0) + 8'h08, 0); wr(chb(0) + 8'h04, 32'd30);
      wr(chb(0) + 8'h08, 0); wr(chb(0) + 8'h04, 32'd40);
      rd(chb(0), v); chk("R7 setval self clear", v, 32'h3);
      rd(chb(0) + 8'h04, v); chk("R7 first write is match", v, 30);
      wr(8'h08, 1);
      for (int k = 0; k < 3; k++) begin
         wait_irq(0); rd(8'h10, v);
         chk("R6 periodic match", v, 30 + 40 * k + 2);
         wr(8'h0C, 1);
      end
      // R11 route readback
      wr(chb(2), 32'h1F0); rd(chb(2), v); chk("R11 route", v, 32'h1F0);
      // R10 legacy routing
      arm(0, 1, 64'd20, 0);
      wr(chb(1), 1); wr(chb(1) + 8'h08, 0); wr(chb(1) + 8'h04, 20);
      wr(8'h0C, 7); wr(8'h08, 3);
      repeat (40) @(negedge clk);
      chk("R10 tmr line", legacy_tmr_irq, 1);
      chk("R10 rtc line", legacy_rtc_irq, 1);
      chk("R10 chan lines masked", chan_irq[1:0], 0);
      wr(8'h08, 0);
      // random one-shots
      for (int k = 0; k < 6; k++) begin
         int ch = int'($urandom % 3);
         int c = 20 + int'($urandom % 150);
         arm(ch, 1, 64'(c), 0); wr(8'h08, 1); wait_irq(ch);
         rd(8'h10, v); chk("R5 random oneshot", v, c + 2);
      end
      done = 1;
      $display("  test done: total=%0d bad=%0d", checks, bad);
      $finish;
   end
endmodule